// File: doc/BRIEF.md
# Reference DAC Slew Ramp Generator

This block produces the digital reference code that feeds a regulator's voltage DAC, one LSB per 10 mV. It does not jump to a new value. It walks the code toward a commanded target at a controlled rate, using a microsecond timebase tick supplied from outside.

After `start`, the code climbs from zero to a fixed boot code at the soft-start rate of 2.5 mV/µs. With the default parameters the boot code is 170, which is 1.7 V. Once the boot code is reached, the block follows target codes loaded through a one-cycle command strobe. Each command selects one of two rates: slow at 2.5 mV/µs, or fast at 10 mV/µs.

A flag reports when the code sits exactly on its target, so that downstream power-good timing can start at that moment.

Top module: `refslew_top`

## Requirements
- R1: After reset, `ref_code` is 0 and `at_target` is 0. Both stay there, whatever `cmd_valid` and `us_tick` do, until `start` is seen.
- R2: A `start` pulse seen while idle begins a soft-start ramp from 0 to BOOT_CODE (default 170). The ramp moves one LSB every SOFT_DIV ticks (default 4), so it needs 680 ticks.
- R3: `at_target` is 1 exactly when the block is active and `ref_code` equals the current target. It rises on the same edge that moves the code onto the target.
- R4: A command strobe during the soft-start ramp is ignored. The ramp still ends at BOOT_CODE at the soft rate.
- R5: After boot, a command with `cmd_fast`=1 ramps one LSB per FAST_DIV ticks (default 1).
- R6: After boot, a command with `cmd_fast`=0 ramps one LSB per SLOW_DIV ticks (default 4).
- R7: Each change of `ref_code` is exactly +1 or -1. The code stops on the target and never passes it, whether ramping up or down.
- R8: Loading a target different from the current one drops `at_target` on the load edge and restarts the tick divider. A tick present on the load cycle does not count, and the first step comes on the Nth later tick.
- R9: A new target loaded mid-ramp takes effect at once. The ramp continues from the present code and reverses direction if needed.
- R10: A target of 0 ramps `ref_code` down to 0 and then raises `at_target`.
- R11: A command whose code equals the current target has no effect. `at_target` stays 1 and `ref_code` is unchanged.
- R12: `start` while already active has no effect on `ref_code` or `at_target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin soft-start ramp (acts only while idle) |
| cmd_valid | input | 1 | One-cycle strobe loading a new target |
| cmd_code | input | CODE_W | New target code, 10 mV per LSB |
| cmd_fast | input | 1 | 1 selects the fast rate, 0 the slow rate |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| ref_code | output | CODE_W | Registered reference code to the DAC |
| at_target | output | 1 | Registered flag: code equals target |

## Verification
Both outputs are registered, so the effect of a start, a command or a tick appears at the edge that samples it. The bench therefore drives inputs at falling edges and compares at the next falling edge. A behavioural predictor pushes one expected code and flag per rising edge into a queue, and a monitor pops and compares them half a cycle later; every step time and every drop of the flag is checked in its exact cycle. On top of that, the ticks between a load or start edge and the rise of `at_target` are counted and checked against the target distance times the divisor. The count leaves out any tick on the load cycle itself.

// File: rtl/refslew_pkg.sv
package refslew_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BOOT = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    RT_SOFT = 2'd0,
    RT_SLOW = 2'd1,
    RT_FAST = 2'd2
  } rate_e;
endpackage

// File: rtl/refslew_prescaler.sv
module refslew_prescaler
  import refslew_pkg::*;
#(
  parameter int SOFT_DIV = 4,
  parameter int SLOW_DIV = 4,
  parameter int FAST_DIV = 1
) (
  input  logic  clk,
  input  logic  rst,
  input  rate_e rate,
  input  logic  tick,
  input  logic  restart,
  output logic  step
);
  localparam int MAX_A   = (SOFT_DIV > SLOW_DIV) ? SOFT_DIV : SLOW_DIV;
  localparam int MAX_DIV = (MAX_A > FAST_DIV) ? MAX_A : FAST_DIV;
  localparam int CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

  logic [CNT_W:0] div_val;

  always_comb begin
    unique case (rate)
      RT_FAST: div_val = (CNT_W+1)'(FAST_DIV);
      RT_SLOW: div_val = (CNT_W+1)'(SLOW_DIV);
      default: div_val = (CNT_W+1)'(SOFT_DIV);
    endcase
  end

  generate
    if (MAX_DIV > 1) begin : g_count
      logic [CNT_W-1:0] cnt_q;
      logic             last;

      assign last = ((CNT_W+1)'(cnt_q) >= (div_val - (CNT_W+1)'(1)));
      assign step = tick && !restart && last;

      always_ff @(posedge clk) begin
        if (rst || restart) begin
          cnt_q <= '0;
        end else if (tick) begin
          if (last) cnt_q <= '0;
          else      cnt_q <= cnt_q + 1'b1;
        end
      end
    end else begin : g_direct
      logic unused_div;
      assign unused_div = ^div_val;
      assign step = tick && !restart;
    end
  endgenerate
endmodule

// File: rtl/refslew_sequencer.sv
module refslew_sequencer
  import refslew_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int BOOT_CODE = 170
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              cmd_fast,
  input  logic [CODE_W-1:0] ref_q,
  output phase_e            state_q,
  output logic              active_d,
  output logic [CODE_W-1:0] tgt_q,
  output logic [CODE_W-1:0] tgt_d,
  output rate_e             rate_q,
  output logic              restart
);
  localparam logic [CODE_W-1:0] BOOT_C = CODE_W'(BOOT_CODE);

  phase_e state_d;
  rate_e  rate_d;

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    rate_d  = rate_q;
    restart = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        restart = 1'b1;
        if (start) begin
          state_d = PH_BOOT;
          tgt_d   = BOOT_C;
          rate_d  = RT_SOFT;
        end
      end
      PH_BOOT: begin
        if (ref_q == tgt_q) state_d = PH_RUN;
      end
      PH_RUN: begin
        if (cmd_valid && (cmd_code != tgt_q)) begin
          tgt_d   = cmd_code;
          rate_d  = cmd_fast ? RT_FAST : RT_SLOW;
          restart = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  assign active_d = (state_d != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PH_IDLE;
      tgt_q   <= '0;
      rate_q  <= RT_SOFT;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      rate_q  <= rate_d;
    end
  end
endmodule

// File: rtl/refslew_stepper.sv
module refslew_stepper #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [CODE_W-1:0] tgt_q,
  input  logic [CODE_W-1:0] tgt_d,
  input  logic              active_d,
  output logic [CODE_W-1:0] ref_q,
  output logic              at_q
);
  logic [CODE_W-1:0] ref_d;

  always_comb begin
    ref_d = ref_q;
    if (step) begin
      if (ref_q < tgt_q)      ref_d = ref_q + 1'b1;
      else if (ref_q > tgt_q) ref_d = ref_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
      at_q  <= 1'b0;
    end else begin
      ref_q <= ref_d;
      at_q  <= active_d && (ref_d == tgt_d);
    end
  end
endmodule

// File: rtl/refslew_top.sv
module refslew_top
  import refslew_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int BOOT_CODE = 170,
  parameter int SOFT_DIV  = 4,
  parameter int SLOW_DIV  = 4,
  parameter int FAST_DIV  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              cmd_fast,
  input  logic              us_tick,
  output logic [CODE_W-1:0] ref_code,
  output logic              at_target
);
  phase_e            state_q;
  rate_e             rate_q;
  logic              active_d;
  logic              restart;
  logic              step;
  logic [CODE_W-1:0] tgt_q;
  logic [CODE_W-1:0] tgt_d;

  refslew_sequencer #(
    .CODE_W   (CODE_W),
    .BOOT_CODE(BOOT_CODE)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cmd_valid(cmd_valid),
    .cmd_code (cmd_code),
    .cmd_fast (cmd_fast),
    .ref_q    (ref_code),
    .state_q  (state_q),
    .active_d (active_d),
    .tgt_q    (tgt_q),
    .tgt_d    (tgt_d),
    .rate_q   (rate_q),
    .restart  (restart)
  );

  refslew_prescaler #(
    .SOFT_DIV(SOFT_DIV),
    .SLOW_DIV(SLOW_DIV),
    .FAST_DIV(FAST_DIV)
  ) u_pre (
    .clk    (clk),
    .rst    (rst),
    .rate   (rate_q),
    .tick   (us_tick),
    .restart(restart),
    .step   (step)
  );

  refslew_stepper #(
    .CODE_W(CODE_W)
  ) u_step (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .tgt_q   (tgt_q),
    .tgt_d   (tgt_d),
    .active_d(active_d),
    .ref_q   (ref_code),
    .at_q    (at_target)
  );
endmodule

// File: rtl/refslew_chk.sv
module refslew_chk
  import refslew_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int BOOT_CODE = 170
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] ref_code,
  input logic              at_target,
  input logic [CODE_W-1:0] tgt_q,
  input phase_e            state_q
);
  localparam logic [CODE_W-1:0] BOOT_C = CODE_W'(BOOT_CODE);

  AST_STEP_UNIT: assert property (@(posedge clk) disable iff (rst)
    (ref_code != $past(ref_code)) |->
      ((ref_code == $past(ref_code) + 1'b1) || (ref_code == $past(ref_code) - 1'b1))); // R7

  AST_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (rst)
    (ref_code < tgt_q) |=> (ref_code <= $past(tgt_q))); // R7

  AST_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (rst)
    (ref_code > tgt_q) |=> (ref_code >= $past(tgt_q))); // R7

  AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    at_target |-> ((ref_code == tgt_q) && (state_q != PH_IDLE))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_IDLE) |-> ((ref_code == '0) && !at_target)); // R1

  AST_BOOT_GOAL: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_BOOT) |-> (tgt_q == BOOT_C)); // R4
endmodule

bind refslew_top refslew_chk #(
  .CODE_W   (CODE_W),
  .BOOT_CODE(BOOT_CODE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ref_code (ref_code),
  .at_target(at_target),
  .tgt_q    (tgt_q),
  .state_q  (state_q)
);

// File: tb/refslew_top_tb_top.sv
`timescale 1ns/1ps
module refslew_top_tb_top;
  localparam int W    = 8;
  localparam int BOOT = 170;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [W-1:0] cmd_code = '0;
  logic         cmd_fast = 1'b0;
  logic         us_tick = 1'b0;
  logic [W-1:0] ref_code;
  logic         at_target;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  refslew_top dut_i (
    .clk(clk), .rst(rst), .start(start), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_fast(cmd_fast), .us_tick(us_tick),
    .ref_code(ref_code), .at_target(at_target)
  );

  // microsecond timebase: one pulse every third cycle, driven at falling edges
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt    <= (tcnt == 2) ? 0 : tcnt + 1;
    us_tick <= (tcnt == 2);
  end

  // predictor: expected outputs after each rising edge
  int     m_state = 0;
  int     m_ref = 0;
  int     m_tgt = 0;
  int     m_div = 4;
  int     m_cnt = 0;
  int     exp_ref_q[$];
  bit     exp_at_q[$];
  string  exp_tag_q[$];

  always @(posedge clk) begin
    int  n_state, n_tgt, n_div, n_ref;
    bit  rs;
    if (rst) begin
      m_state = 0; m_ref = 0; m_tgt = 0; m_div = 4; m_cnt = 0;
      exp_ref_q.push_back(0); exp_at_q.push_back(1'b0); exp_tag_q.push_back("R1");
    end else begin
      n_state = m_state; n_tgt = m_tgt; n_div = m_div; n_ref = m_ref; rs = 1'b0;
      case (m_state)
        0: begin
          rs = 1'b1;
          if (start) begin n_state = 1; n_tgt = BOOT; n_div = 4; end
        end
        1: if (m_ref == m_tgt) n_state = 2;
        default: if (cmd_valid && (int'(cmd_code) != m_tgt)) begin
          n_tgt = int'(cmd_code); n_div = cmd_fast ? 1 : 4; rs = 1'b1;
        end
      endcase
      if (rs) m_cnt = 0;
      else if (us_tick) begin
        if (m_cnt >= m_div - 1) begin
          m_cnt = 0;
          if (m_ref < m_tgt) n_ref = m_ref + 1;
          else if (m_ref > m_tgt) n_ref = m_ref - 1;
        end else m_cnt = m_cnt + 1;
      end
      m_state = n_state; m_tgt = n_tgt; m_div = n_div; m_ref = n_ref;
      exp_ref_q.push_back(m_ref);
      exp_at_q.push_back((m_state != 0) && (m_ref == m_tgt));
      exp_tag_q.push_back(tag);
    end
  end

  // monitor: compare half a cycle after each edge
  int prev_ref = 0;
  int jump_bad = 0;
  always @(negedge clk) begin
    int    er;
    bit    ea;
    string et;
    if (!done && exp_ref_q.size() > 0) begin
      er = exp_ref_q.pop_front(); ea = exp_at_q.pop_front(); et = exp_tag_q.pop_front();
      n_cmp++;
      if (int'(ref_code) != er || at_target !== ea) begin
        n_bad++;
        $display("FAIL %s scoreboard: ref=%0d at=%0b expected ref=%0d at=%0b",
                 et, ref_code, at_target, er, ea);
      end
      if ((int'(ref_code) - prev_ref > 1) || (prev_ref - int'(ref_code) > 1)) jump_bad++;
      prev_ref = int'(ref_code);
    end
  end

  task automatic chk(input bit ok, input string t, input int act, input int exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, exp_v);
    end
  endtask

  task automatic load(input int code, input bit fast);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = W'(code); cmd_fast = fast;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // count ticks on edges until at_target rises; returns at a falling edge
  task automatic run_to(input string t, input int exp_ticks, input int exp_code);
    int n = 0;
    bit hit = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      @(posedge clk);
      if (us_tick) n++;
      @(negedge clk);
      if (at_target) begin hit = 1'b1; break; end
    end
    chk(hit && n == exp_ticks, t, n, exp_ticks);
    chk(int'(ref_code) == exp_code, t, int'(ref_code), exp_code);
  endtask

  task automatic wait_ticks(input int k);
    int n = 0;
    while (n < k) begin
      @(posedge clk);
      if (us_tick) n++;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(ref_code == 0 && !at_target, "R1 reset", int'(ref_code), 0);
    rst = 1'b0;
    // R1: commands before start are ignored
    tag = "R1";
    cmd_valid = 1'b1; cmd_code = 8'd50; cmd_fast = 1'b1;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(ref_code == 0 && !at_target, "R1 idle", int'(ref_code), 0);

    // R2 soft start, R4 command during boot ignored
    tag = "R2";
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_ticks(40);
    tag = "R4";
    load(30, 1'b1);
    chk(int'(ref_code) == 10, "R4 mid-boot", int'(ref_code), 10);
    run_to("R2", 680 - 40 - 0, BOOT);
    chk(at_target == 1'b1, "R3 flag at boot", at_target, 1);

    // R5 fast down
    tag = "R5";
    load(100, 1'b1);
    chk(at_target == 1'b0, "R8 flag drop", at_target, 0);
    run_to("R5", 70, 100);

    // R6 slow up
    tag = "R6";
    load(120, 1'b0);
    run_to("R6", 80, 120);

    // R11 same target
    tag = "R11";
    load(120, 1'b1);
    chk(at_target == 1'b1 && ref_code == 120, "R11 same target", int'(ref_code), 120);
    wait_ticks(6);
    chk(at_target == 1'b1 && ref_code == 120, "R11 hold", int'(ref_code), 120);

    // R9 retarget mid-ramp
    tag = "R9";
    load(200, 1'b1);
    wait_ticks(10);
    chk(int'(ref_code) == 130, "R9 mid", int'(ref_code), 130);
    load(150, 1'b0);
    run_to("R9", 80, 150);
    load(60, 1'b1);
    wait_ticks(5);
    chk(int'(ref_code) == 145, "R9 reverse", int'(ref_code), 145);
    load(170, 1'b1);
    run_to("R9", 25, 170);

    // R10 ramp to zero
    tag = "R10";
    load(0, 1'b1);
    run_to("R10", 170, 0);

    // R12 start while active
    tag = "R12";
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_ticks(12);
    chk(ref_code == 0 && at_target, "R12 start ignored", int'(ref_code), 0);

    chk(jump_bad == 0, "R7 unit steps", jump_bad, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule